// File: doc/BRIEF.md
# Return Address Stack

This block keeps the program-counter values that a small 8-bit controller core must come back to after a subroutine or an interrupt routine. A call, or an interrupt that is granted, writes the current program counter onto the stack. The address on top of the stack is always visible on `ret_addr`. A return strobe removes that top entry, so the next older address then shows on `ret_addr`. Instructions cannot read or write the stack storage or its level pointer. The core reaches the stack only through these strobes.

The depth (4 or 6 levels) and the program-counter width are parameters. Once every level holds an address, the block raises `stack_full`. In that state it holds back acknowledgment of a pending interrupt: `irq_grant` stays low until a return frees a level. A call made while the stack is full is still accepted. It overwrites the oldest saved address, so the stack keeps the most recent DEPTH return addresses.

Top module: `ras_stack`

## Requirements
- R1: After reset the stack holds no entries and `stack_full` is 0.
- R2: A cycle with `call_push` high stores `pc_in`. From the next cycle, `ret_addr` shows that value for as long as it is the newest entry.
- R3: A cycle with `ret_pop` high (and no push) on a non-empty stack discards the newest entry. From the next cycle, `ret_addr` shows the entry below it, so addresses come back newest first.
- R4: `stack_full` is 1 exactly when the number of stored entries equals DEPTH.
- R5: `irq_grant` equals `irq_req AND NOT stack_full AND NOT call_push`, combinationally in the same cycle. A granted interrupt stores `pc_in` just as a call does.
- R6: A call while the stack is full overwrites the oldest entry. The entry count stays at DEPTH, and the DEPTH most recent addresses remain in newest-first order.
- R7: A return on an empty stack changes nothing. The entry count stays zero, so exactly DEPTH later pushes are needed before `stack_full` rises.
- R8: When a push and `ret_pop` arrive in the same cycle, the push is performed and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_push | input | 1 | Single-cycle strobe: subroutine call saves `pc_in` |
| irq_req | input | 1 | Interrupt pending from the interrupt controller |
| ret_pop | input | 1 | Single-cycle strobe: return instruction consumes the top entry |
| pc_in | input | PC_W | Program counter to be saved |
| irq_grant | output | 1 | Interrupt acknowledgment allowed this cycle (causes a push) |
| ret_addr | output | PC_W | Newest saved address; undefined while empty |
| stack_full | output | 1 | All DEPTH levels occupied |

## Verification
The assertions assume that the strobes are sampled only after reset has been released. They also assume that `ret_addr` is used only while the stack is non-empty, and they make no claim about its value while the stack is empty. The stimulus applies every input combination, including call with return and a return on an empty stack, and it drives all inputs away from the clock edge. The reference queue in the bench compares `ret_addr` only while it holds at least one entry.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } ras_op_e;

    function automatic ras_op_e ras_decode(input logic push, input logic pop, input logic empty);
        if (push) begin
            return OP_PUSH;
        end else if (pop && !empty) begin
            return OP_POP;
        end
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic             full_o,
    output logic             empty_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
    } ctrl_state_t;

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    ctrl_state_t s_d, s_q;
    ras_op_e     op;

    function automatic logic [PTR_W-1:0] idx_inc(input logic [PTR_W-1:0] i);
        return (i == LAST_IDX) ? '0 : i + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] idx_dec(input logic [PTR_W-1:0] i);
        return (i == '0) ? LAST_IDX : i - PTR_W'(1);
    endfunction

    assign full_o   = (s_q.cnt == CNT_MAX);
    assign empty_o  = (s_q.cnt == '0);
    assign wr_idx_o = s_q.ptr;
    assign rd_idx_o = idx_dec(s_q.ptr);

    always_comb begin
        s_d     = s_q;
        wr_en_o = 1'b0;
        op      = ras_decode(push_i, pop_i, empty_o);
        case (op)
            OP_PUSH: begin
                wr_en_o = 1'b1;
                s_d.ptr = idx_inc(s_q.ptr);
                if (!full_o) begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            OP_POP: begin
                s_d.ptr = idx_dec(s_q.ptr);
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R4: the last free level taken makes the stack full
    a_r4_fill_to_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && s_q.cnt == CNT_W'(DEPTH - 1)) |=> full_o);

    // R6: overflow keeps the stack full
    a_r6_overflow_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |=> full_o);

    // R7: empty pop leaves pointer and count alone
    a_r7_empty_pop_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> ($stable(s_q.ptr) && empty_o));

    // R3: a real pop frees exactly one level
    a_r3_pop_frees_level: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> (!full_o && s_q.cnt == $past(s_q.cnt) - CNT_W'(1)));

    // R8: push wins over a simultaneous pop
    a_r8_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !full_o) |=> (s_q.cnt == $past(s_q.cnt) + CNT_W'(1)));

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH = 4,
    parameter int PC_W  = 11,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [PC_W-1:0]  wr_data_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [PC_W-1:0]  rd_data_o
);

    logic [PC_W-1:0] lvl_q [DEPTH];
    logic [PC_W-1:0] lvl_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_level
        always_comb begin
            lvl_d[g] = lvl_q[g];
            if (wr_en_i && wr_idx_i == PTR_W'(g)) begin
                lvl_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[g] <= '0;
            end else begin
                lvl_q[g] <= lvl_d[g];
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx_i == PTR_W'(i)) begin
                rd_data_o = lvl_q[i];
            end
        end
    end

endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
    parameter int DEPTH = 4,
    parameter int PC_W  = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_push,
    input  logic            irq_req,
    input  logic            ret_pop,
    input  logic [PC_W-1:0] pc_in,
    output logic            irq_grant,
    output logic [PC_W-1:0] ret_addr,
    output logic            stack_full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             push;
    logic             wr_en;
    logic             empty;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;

    assign irq_grant = irq_req && !stack_full && !call_push;
    assign push      = call_push || irq_grant;

    ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push),
        .pop_i    (ret_pop),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx),
        .full_o   (stack_full),
        .empty_o  (empty)
    );

    ras_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (pc_in),
        .rd_idx_i  (rd_idx),
        .rd_data_o (ret_addr)
    );

    // R5: no acknowledgment while every level is occupied
    a_r5_no_grant_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        stack_full |-> !irq_grant);

    // R2: the pushed address is on top in the following cycle
    a_r2_top_is_last_push: assert property (@(posedge clk) disable iff (!rst_n)
        (call_push || irq_grant) |=> (ret_addr == $past(pc_in) && !empty));

endmodule

// File: tb/ras_stack_tb_top.sv
module ras_stack_tb_top;

    localparam int D  = 4;
    localparam int PW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_push = 1'b0;
    logic          irq_req = 1'b0;
    logic          ret_pop = 1'b0;
    logic [PW-1:0] pc_in = '0;
    logic          irq_grant;
    logic [PW-1:0] ret_addr;
    logic          stack_full;

    int checks = 0;
    int errors = 0;
    int model_q[$];

    always #2 clk = ~clk;

    ras_stack #(.DEPTH(D), .PC_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .call_push(call_push), .irq_req(irq_req),
        .ret_pop(ret_pop), .pc_in(pc_in), .irq_grant(irq_grant),
        .ret_addr(ret_addr), .stack_full(stack_full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: drive, check grant, clock, update model, check outputs
    task automatic step(input string tag, input logic c, input logic i, input logic r, input int pc);
        logic eg;
        @(negedge clk);
        call_push = c;
        irq_req   = i;
        ret_pop   = r;
        pc_in     = PW'(pc);
        #1;
        eg = i && (model_q.size() < D) && !c;
        chk({tag, "/R5 grant"}, int'(irq_grant), int'(eg));
        @(posedge clk);
        #1;
        if (c || eg) begin
            model_q.push_back(pc);
            if (model_q.size() > D) void'(model_q.pop_front());
        end else if (r && model_q.size() > 0) begin
            void'(model_q.pop_back());
        end
        chk({tag, "/R4 full"}, int'(stack_full), int'(model_q.size() == D));
        if (model_q.size() > 0)
            chk({tag, "/top"}, int'(ret_addr), model_q[$]);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 full after reset", int'(stack_full), 0);

        // R7: pops on empty, then exactly D pushes to full
        step("R7 empty pop", 0, 0, 1, 0);
        step("R7 empty pop", 0, 0, 1, 0);
        for (int k = 0; k < D; k++) begin
            step("R2 fill", 1, 0, 0, 100 + k);
            chk("R7 full only at D", int'(stack_full), int'(k == D - 1));
        end

        // R5: interrupt pending while full is held off until a return
        step("R5 irq held", 0, 1, 0, 300);
        step("R5 irq held", 0, 1, 0, 301);
        step("R3 return frees", 0, 1, 1, 302);
        step("R5 irq granted", 0, 1, 0, 303);
        chk("R5 irq address on top", int'(ret_addr), 303);
        step("R5 irq held again", 0, 1, 0, 304);

        // R6: calls while full drop oldest
        for (int k = 0; k < 3; k++) step("R6 overflow", 1, 0, 0, 500 + k);
        for (int k = 0; k < D; k++) step("R3 unwind", 0, 0, 1, 0);
        chk("R6 empty after D pops", int'(stack_full), 0);
        step("R7 empty pop after unwind", 0, 0, 1, 0);

        // R8: push with pop, push wins
        step("R8 base", 1, 0, 0, 700);
        step("R8 both", 1, 0, 1, 701);
        chk("R8 pushed on top", int'(ret_addr), 701);
        step("R3 pop", 0, 0, 1, 0);
        chk("R8 older still present", int'(ret_addr), 700);
        step("R3 pop", 0, 0, 1, 0);

        // R5: call and irq together, call wins the push
        step("R5 call with irq", 1, 1, 0, 800);

        // mixed pattern
        for (int k = 0; k < 400; k++) begin
            step("R2 mixed", logic'((k * 7 + 3) % 5 == 0), logic'((k * 3) % 4 == 1),
                 logic'((k * 5) % 3 == 0), (k * 37) % 2048);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule